// File: doc/BRIEF.md
# Partitioned Packed-Lane Adder with Equality Mask

This block treats two 64-bit operands as groups of equal-width packed elements and applies one operation to every element in the same cycle. A two-bit size code chooses the element width (bytes, 16-bit halves, 32-bit halves or the whole 64-bit word). A two-bit function code chooses between addition, subtraction and an equality compare. Every lane of the word is always processed. There is no length control, and elements are contiguous.

Addition and subtraction run along one carry chain made of byte-wide segments. At each element boundary the chain is cut, so no carry or borrow ever reaches the next element. Arithmetic wraps modulo the element width. The compare produces a mask element of all ones or all zeros. Software uses that mask for overlay blending, `out = (X & mask) | (Y & ~mask)`, which chooses per element between two images. The result is held in a register and appears one clock after the inputs are sampled.

Top module: `pkd_simd_alu`

## Requirements
- R1: While `rst_n` is low, `result` is all zeros, and it clears as soon as reset is asserted, even in the middle of a run.
- R2: `result` changes only at a rising clock edge and shows the operation on the inputs sampled at that edge. It holds its value between edges.
- R3: `elem_sz` encodes the element width as follows: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 is 64 bits. With `func_sel` = 2'b00, each element of `result` equals the sum of the matching elements of `opnd_a` and `opnd_b`, modulo 2^width.
- R4: No carry out of an element's top bit reaches the element above it, in any of the four sizes.
- R5: With `func_sel` = 2'b01, each element equals `opnd_a` minus `opnd_b`, modulo 2^width, and no borrow crosses an element boundary.
- R6: With `func_sel[1]` = 1 (codes 2'b10 and 2'b11), each element is all ones if the two operand elements are equal and all zeros otherwise.
- R7: All elements of the 64-bit word are processed in every operation, including the topmost element.
- R8: A compare mask used as `(X & mask) | (Y & ~mask)` selects X in exactly the elements where the compared operands matched, and Y in all other elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 64 | First packed operand (minuend for subtraction) |
| opnd_b | input | 64 | Second packed operand |
| elem_sz | input | 2 | Element width code |
| func_sel | input | 2 | Operation: 00 add, 01 subtract, 1x compare-equal |
| result | output | 64 | Registered packed result |

## Verification
A change of element size and a change of function can arrive in the same cycle, with no idle cycle between back-to-back operations. The bench provokes this by moving through size and function in interleaved sequences, so that each edge samples a new pair. Each result is compared against a per-element reference computed with integer arithmetic. Reset can also arrive while operands are active. The bench asserts reset in mid-cycle after a nonzero result and checks for zero before the next edge.

// File: rtl/pkd_simd_pkg.sv
`timescale 1ns/1ps
package pkd_simd_pkg;
   typedef enum logic [1:0] {
      ESZ_8  = 2'b00,
      ESZ_16 = 2'b01,
      ESZ_32 = 2'b10,
      ESZ_64 = 2'b11
   } esz_e;

   typedef enum logic [1:0] {
      FN_ADD  = 2'b00,
      FN_SUB  = 2'b01,
      FN_CMP  = 2'b10,
      FN_CMP2 = 2'b11
   } fn_e;

   // number of byte segments grouped into one element for a size code
   function automatic int unsigned seg_per_elem(input logic [1:0] sz);
      return 32'd1 << sz;
   endfunction
endpackage

// File: rtl/pkd_seg_cut.sv
`timescale 1ns/1ps
// Decodes which segment boundaries (1..NSEG-1) start a new element.
module pkd_seg_cut #(
   parameter int NSEG = 8
) (
   input  logic [1:0]      elem_sz,
   output logic [NSEG-1:1] cut
);
   import pkd_simd_pkg::*;

   always_comb begin
      int unsigned span;
      span = seg_per_elem(elem_sz);
      for (int i = 1; i < NSEG; i++) begin
         cut[i] = ((i & (span - 1)) == 0);
      end
   end
endmodule

// File: rtl/pkd_lane_adder.sv
`timescale 1ns/1ps
// Segmented ripple adder: each segment takes its carry either from the
// segment below or, at an element boundary, from the subtract flag.
module pkd_lane_adder #(
   parameter int NSEG  = 8,
   parameter int SEG_W = 8,
   localparam int W    = NSEG * SEG_W
) (
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic            sub,
   input  logic [NSEG-1:1] cut,
   output logic [W-1:0]    sum
);
   logic [NSEG-1:0] cin;
   logic [NSEG-2:0] cout;

   genvar g;
   generate
      for (g = 0; g < NSEG; g++) begin : g_seg
         logic [SEG_W-1:0] bx;
         assign bx = b[g*SEG_W +: SEG_W] ^ {SEG_W{sub}};

         if (g == 0) begin : g_first
            assign cin[g] = sub;
         end else begin : g_rest
            assign cin[g] = cut[g] ? sub : cout[g-1];
         end

         if (g < NSEG - 1) begin : g_carry
            logic [SEG_W:0] wide;
            assign wide = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, bx}
                        + {{SEG_W{1'b0}}, cin[g]};
            assign sum[g*SEG_W +: SEG_W] = wide[SEG_W-1:0];
            assign cout[g] = wide[SEG_W];
         end else begin : g_top
            assign sum[g*SEG_W +: SEG_W] = a[g*SEG_W +: SEG_W] + bx
                                          + {{(SEG_W-1){1'b0}}, cin[g]};
         end
      end
   endgenerate
endmodule

// File: rtl/pkd_eq_mask.sv
`timescale 1ns/1ps
// Per-element equality mask: a segment is all ones when every segment of
// its element compares equal.
module pkd_eq_mask #(
   parameter int NSEG  = 8,
   parameter int SEG_W = 8,
   localparam int W    = NSEG * SEG_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   elem_sz,
   output logic [W-1:0] mask
);
   import pkd_simd_pkg::*;

   logic [NSEG-1:0] seg_eq;

   genvar g;
   generate
      for (g = 0; g < NSEG; g++) begin : g_eq
         assign seg_eq[g] = (a[g*SEG_W +: SEG_W] == b[g*SEG_W +: SEG_W]);
      end
   endgenerate

   always_comb begin
      int unsigned span;
      int unsigned base;
      logic        all_eq;
      span = seg_per_elem(elem_sz);
      for (int i = 0; i < NSEG; i++) begin
         base   = i & ~(span - 1);
         all_eq = 1'b1;
         for (int j = 0; j < NSEG; j++) begin
            if (j >= base && j < base + span) all_eq = all_eq & seg_eq[j];
         end
         mask[i*SEG_W +: SEG_W] = {SEG_W{all_eq}};
      end
   end
endmodule

// File: rtl/pkd_simd_alu.sv
`timescale 1ns/1ps
module pkd_simd_alu #(
   parameter int DATA_W = 64,
   parameter int BASE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [1:0]        elem_sz,
   input  logic [1:0]        func_sel,
   output logic [DATA_W-1:0] result
);
   import pkd_simd_pkg::*;

   localparam int NSEG = DATA_W / BASE_W;

   generate
      if (BASE_W < 1) begin : g_bad_base
         $error("pkd_simd_alu: BASE_W must be positive");
      end
      if (DATA_W != 8 * BASE_W) begin : g_bad_width
         $error("pkd_simd_alu: DATA_W must hold exactly eight base segments");
      end
   endgenerate

   logic [NSEG-1:1]   cut;
   logic [DATA_W-1:0] arith;
   logic [DATA_W-1:0] eq_mask;
   logic [DATA_W-1:0] nxt;
   logic              is_sub;
   logic              is_cmp;

   assign is_sub = (func_sel == FN_SUB);
   assign is_cmp = func_sel[1];

   pkd_seg_cut #(.NSEG(NSEG)) u_cut (
      .elem_sz (elem_sz),
      .cut     (cut)
   );

   pkd_lane_adder #(.NSEG(NSEG), .SEG_W(BASE_W)) u_add (
      .a   (opnd_a),
      .b   (opnd_b),
      .sub (is_sub),
      .cut (cut),
      .sum (arith)
   );

   pkd_eq_mask #(.NSEG(NSEG), .SEG_W(BASE_W)) u_eq (
      .a       (opnd_a),
      .b       (opnd_b),
      .elem_sz (elem_sz),
      .mask    (eq_mask)
   );

   assign nxt = is_cmp ? eq_mask : arith;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= nxt;
   end
endmodule

// File: rtl/pkd_simd_alu_chk.sv
`timescale 1ns/1ps
module pkd_simd_alu_chk #(
   parameter int DATA_W = 64,
   parameter int BASE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [1:0]        elem_sz,
   input logic [1:0]        func_sel,
   input logic [DATA_W-1:0] result
);
   localparam int NSEG = DATA_W / BASE_W;

   logic              armed;
   logic [DATA_W-1:0] p_a, p_b;
   logic [1:0]        p_sz, p_fn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         p_a   <= '0;
         p_b   <= '0;
         p_sz  <= '0;
         p_fn  <= '0;
      end else begin
         armed <= 1'b1;
         p_a   <= opnd_a;
         p_b   <= opnd_b;
         p_sz  <= elem_sz;
         p_fn  <= func_sel;
      end
   end

   function automatic logic [DATA_W-1:0] low_mask(input logic [1:0] sz);
      logic [DATA_W-1:0] m;
      int unsigned w;
      w = BASE_W << sz;
      for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
      return m;
   endfunction

   function automatic logic uniform_mask(input logic [DATA_W-1:0] v,
                                         input logic [1:0] sz);
      logic ok;
      int unsigned span;
      int unsigned base;
      ok   = 1'b1;
      span = 32'd1 << sz;
      for (int i = 0; i < NSEG; i++) begin
         base = i & ~(span - 1);
         if (v[i*BASE_W +: BASE_W] != {BASE_W{1'b0}} &&
             v[i*BASE_W +: BASE_W] != {BASE_W{1'b1}}) ok = 1'b0;
         if (v[i*BASE_W +: BASE_W] != v[base*BASE_W +: BASE_W]) ok = 1'b0;
      end
      return ok;
   endfunction

   // R1: asynchronous clear holds while reset is low
   always @(posedge clk) begin
      if (!rst_n) assert_reset_zero_R1: assert (result == '0);
   end

   // R3: lowest element equals the plain low-order sum
   assert_low_lane_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_fn == 2'b00) |->
      (((result ^ (p_a + p_b)) & low_mask(p_sz)) == '0));

   // R4: quadword mode carries across all bytes
   assert_quad_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_fn == 2'b00 && p_sz == 2'b11) |-> (result == p_a + p_b));

   // R5: subtracting an operand from itself yields zero in every size
   assert_self_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_fn == 2'b01 && p_a == p_b) |-> (result == '0));

   // R6: compare output is an element-uniform all-ones/all-zeros pattern
   assert_cmp_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_fn[1]) |-> uniform_mask(result, p_sz));

   // R6: identical operands compare equal everywhere
   assert_cmp_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_fn[1] && p_a == p_b) |-> (result == '1));
endmodule

bind pkd_simd_alu pkd_simd_alu_chk #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .elem_sz  (elem_sz),
   .func_sel (func_sel),
   .result   (result)
);

// File: tb/pkd_simd_alu_bench.sv
`timescale 1ns/1ps
module pkd_simd_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [1:0]  elem_sz = '0;
   logic [1:0]  func_sel = '0;
   logic [63:0] result;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [63:0] last_exp = '0;

   always #5 clk = ~clk;

   pkd_simd_alu u_pkd_simd_alu (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .elem_sz(elem_sz), .func_sel(func_sel), .result(result)
   );

   // behavioural per-element reference
   function automatic logic [63:0] ref_op(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] sz, input logic [1:0] fn);
      logic [63:0] r, m, ea, eb, ee;
      int w;
      w = 8 << sz;
      m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      r = '0;
      for (int e = 0; e < 64 / w; e++) begin
         ea = (a >> (e * w)) & m;
         eb = (b >> (e * w)) & m;
         if (fn[1])           ee = (ea == eb) ? m : 64'd0;
         else if (fn == 2'b01) ee = (ea - eb) & m;
         else                 ee = (ea + eb) & m;
         r = r | (ee << (e * w));
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a negedge, verify hold before the edge, check after it
   task automatic step(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sz, input logic [1:0] fn, input string tag);
      opnd_a = a; opnd_b = b; elem_sz = sz; func_sel = fn;
      #1;
      check("R2 hold", result, last_exp);
      @(negedge clk);
      last_exp = ref_op(a, b, sz, fn);
      check(tag, result, last_exp);
   endtask

   function automatic string tag_of(input logic [1:0] fn);
      return fn[1] ? "R6 cmp" : (fn == 2'b01 ? "R5 sub" : "R3 add");
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] img_x, img_y, key, msk, blend, want;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", result, 64'd0);

      // R4: carry isolation with all-ones plus one in every size
      for (int s = 0; s < 4; s++)
         step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, s[1:0], 2'b00, "R4 carry cut");
      step(64'h80FF_7FFF_00FF_FF80, 64'h8001_0101_0001_0180, 2'b00, 2'b00, "R4 bytes");
      // R5: borrow isolation
      for (int s = 0; s < 4; s++)
         step(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, s[1:0], 2'b01, "R5 borrow cut");
      step(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b10, 2'b01, "R5 self");
      // R6: compare with partial matches
      step(64'h1122_3344_5566_7788, 64'h1122_3300_5566_0088, 2'b00, 2'b10, "R6 bytes");
      step(64'h1122_3344_5566_7788, 64'h1122_3300_5566_0088, 2'b01, 2'b11, "R6 halves");
      step(64'h1122_3344_5566_7788, 64'h1122_3344_5566_0088, 2'b10, 2'b10, "R6 words");
      step(64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 2'b11, 2'b10, "R6 quad");
      // R7: only the top element differs
      step(64'hFE00_0000_0000_0000, 64'h0300_0000_0000_0000, 2'b00, 2'b00, "R7 top lane");
      step(64'hAB00_0000_0000_0000, 64'h0000_0000_0000_0000, 2'b00, 2'b10, "R7 top cmp");

      // R8: overlay of image X over Y where X pixel equals key colour
      img_x = 64'h10_20_30_20_20_50_60_20;
      img_y = 64'hA1_B2_C3_D4_E5_F6_07_18;
      key   = 64'h20_20_20_20_20_20_20_20;
      step(img_x, key, 2'b00, 2'b10, "R6 overlay mask");
      msk   = result;
      blend = (img_y & msk) | (img_x & ~msk);
      want  = '0;
      for (int e = 0; e < 8; e++)
         want[e*8 +: 8] = (img_x[e*8 +: 8] == 8'h20) ? img_y[e*8 +: 8] : img_x[e*8 +: 8];
      check("R8 overlay", blend, want);

      // size and function changing together every cycle
      for (int k = 0; k < 400; k++) begin
         logic [63:0] ra, rb;
         logic [1:0] sz, fn;
         ra = {$urandom, $urandom};
         rb = (k % 5 == 0) ? ra ^ (64'hFF << (8 * (k % 8))) : {$urandom, $urandom};
         sz = 2'(k % 4);
         fn = 2'((k / 4 + k) % 4);
         step(ra, rb, sz, fn, tag_of(fn));
      end

      // R1: reset in mid-cycle after a nonzero result
      step(64'h5, 64'h7, 2'b11, 2'b00, "R3 pre-reset");
      #2 rst_n = 1'b0;
      #1 check("R1 async clear", result, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      last_exp = '0;
      step(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 2'b01, 2'b00, "R3 after reset");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule